// File: doc/BRIEF.md
# Half-Duplex Two-Wire Serial Port

This block is the device side of a serial port in which one bidirectional data pin carries both directions of traffic. An external master supplies a serial clock and an active-low select. The port first shifts in a 16-bit write word on rising clock edges. The pin then turns around and the port shifts out a 16-bit read word on falling clock edges. After that read word the pin becomes an input again. The port counts clock edges to find each turnaround, so it also works when the select is tied low permanently. While the select is high, the pin driver is off.

All three serial inputs pass through two-flop synchronizers and are treated as edges in the system clock domain. Each complete write word is handed over in parallel on a one-cycle strobe. A word whose mode bit is clear is rejected on an error strobe instead. A command word can ask for a conversion start, or it can open a calibration burst. A burst is several consecutive write words or several consecutive read words, and the pin keeps its direction for the whole burst. A burst cannot be aborted: the select going high only suspends the count. The burst length comes from a parallel input that is sampled when the command word completes.

Write word fields: bit 0 is the mode bit, bits 2:1 are the burst request, and bit 3 is the conversion request.

Top module: `hdx_serial_port`

## Requirements
- R1: Data bits are captured on rising serial clock edges while select is low, most significant bit first. After the 16th rising edge of a write word, the word appears on `wr_word` with `wr_valid` high for exactly one system clock.
- R2: A write word whose bit 0 (mode bit) is 0 raises `wr_err` for one cycle and never raises `wr_valid`. Its burst and conversion fields are ignored, and the port turns around for a single read word.
- R3: In the read phase, the first falling edge while select is low loads `rd_word` and drives bit 15 on `sdo`. Each following falling edge drives the next lower bit. `sdo` changes only in response to a falling edge.
- R4: While select is high, `sdo_oe` is low. `sdo_oe` is never high during a write phase.
- R5: After the 16th rising edge of the last read word, the pin returns to input and the port expects a write word. With select held low permanently, writes and reads keep alternating every 16 edges, and the phase changes only at a word boundary.
- R6: Clock edges while select is high are ignored. Raising select in the middle of a word keeps the bit position, and the word resumes when select falls again.
- R7: A command word with mode bit 1, bits 2:1 = 2'b10 and a nonzero `cal_len` N is followed by N read words. `sdo_oe` stays high across all N words.
- R8: A command word with mode bit 1, bits 2:1 = 2'b01 and a nonzero `cal_len` N keeps the pin an input for N further write words. Each of those words is forwarded, then a single read word follows.
- R9: `conv_start` pulses together with `wr_valid` only for a command word that has bit 3 set. Burst data words never cause a conversion start.
- R10: After reset, the bit position is zero, the port is in the write phase, and `sdo_oe`, `sdo`, `wr_valid`, `wr_err` and `conv_start` are low.
- R11: A burst request with `cal_len` = 0 behaves like a normal word: one read word follows, then a write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the master, asynchronous |
| sel_n_in | input | 1 | Active-low select, asynchronous |
| sdi_in | input | 1 | Data pin as seen by the input buffer |
| cal_len | input | LEN_W | Calibration burst length, sampled at command word end |
| rd_word | input | WORD_W | Parallel word returned in the read phase |
| sdo | output | 1 | Value driven onto the data pin |
| sdo_oe | output | 1 | Output enable of the data pin driver |
| wr_word | output | WORD_W | Last accepted write word |
| wr_valid | output | 1 | One-cycle strobe for an accepted write word |
| wr_err | output | 1 | One-cycle strobe for a write word with mode bit clear |
| conv_start | output | 1 | One-cycle conversion start request |

## Verification
The bench sweeps arithmetic write and read patterns, plus a walking one on every data bit. It runs them once with a pulsed select and once with select held low. A port that counted edges wrongly would give shifted words or a pin that turns around one edge early. The bench suspends a word with select high and sends junk clocks meanwhile; a design that reset or counted on deselect would return a corrupted word. It runs read and write calibration bursts, a zero-length burst request and a rejected command that carries a burst request. A design that dropped its direction between burst words, or that honoured fields of a bad word, would show the pin enabled in the wrong phase or too many or too few forwarded words. Conversion requests are counted over the whole run, so a pulse from a burst data word would show up as an extra start.

// File: rtl/hdx_pkg.sv
// Shared types and field positions for the half-duplex serial port.
package hdx_pkg;

    // Direction of the shared pin as seen by the port.
    typedef enum logic {
        PH_WR = 1'b0,
        PH_RD = 1'b1
    } hdx_phase_e;

    // Burst request field of a command word.
    typedef enum logic [1:0] {
        BR_NONE   = 2'b00,
        BR_CAL_WR = 2'b01,
        BR_CAL_RD = 2'b10,
        BR_RSVD   = 2'b11
    } hdx_burst_e;

    localparam int MODE_POS  = 0;
    localparam int BURST_LSB = 1;
    localparam int CONV_POS  = 3;

endpackage

// File: rtl/hdx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; no cross-bit coherence is promised.
module hdx_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hdx_edge.sv
// Rising and falling edge detector for a synchronized serial clock.
// Edges are reported only while the enable (select active) is high.
module hdx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember the previous level so that transitions can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = en &  lvl & ~prev;
    assign fall = en & ~lvl &  prev;
endmodule

// File: rtl/hdx_shift.sv
// Receive and transmit shift registers of the serial port.
// Receive shifts on rising edges in the write phase. Transmit loads the
// parallel read word on the first falling edge of a read word and shifts
// the word out MSB first.
module hdx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    input  logic              phase_rd,
    input  logic              bit_zero,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] word_full,
    output logic              sdo
);
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;

    // The word as it stands once the current input bit is appended.
    assign word_full = {rx_sh[WORD_W-2:0], sdi};

    // Collect write bits on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rx_sh <= '0;
        else if (rise && !phase_rd)  rx_sh <= word_full;
    end

    // Load or advance the read word on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            sdo   <= 1'b0;
        end else if (fall && phase_rd) begin
            if (bit_zero) begin
                sdo   <= rd_word[WORD_W-1];
                tx_sh <= {rd_word[WORD_W-2:0], 1'b0};
            end else begin
                sdo   <= tx_sh[WORD_W-1];
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/hdx_phase_ctl.sv
// Bit counter and phase sequencer of the serial port.
// Tracks the position within a word, the pin direction and the remaining
// words of a calibration burst. Decodes completed write words into
// strobes. Bursts are counted only on edges, so deselect cannot abort one.
module hdx_phase_ctl
    import hdx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 3,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic [WORD_W-1:0] word_in,
    input  logic [LEN_W-1:0]  cal_len,
    output hdx_phase_e        phase,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [WORD_W-1:0] wr_word,
    output logic              wr_valid,
    output logic              wr_err,
    output logic              conv_start
);
    logic [LEN_W-1:0] wr_left, rd_left;
    logic [LEN_W-1:0] wr_left_n, rd_left_n;
    hdx_phase_e       phase_n;
    logic             last_bit, wdone, mode_ok, is_cmd, len_nz;
    hdx_burst_e       burst;

    assign last_bit = (bit_cnt == CNT_W'(WORD_W-1));
    assign wdone    = rise & last_bit;
    assign mode_ok  = word_in[MODE_POS];
    assign burst    = hdx_burst_e'(word_in[BURST_LSB +: 2]);
    assign is_cmd   = (wr_left == '0);
    assign len_nz   = (cal_len != '0);

    // Count bit positions; wrap at the end of every word.
    always_ff @(posedge clk) begin
        if (!rst_n)    bit_cnt <= '0;
        else if (rise) bit_cnt <= last_bit ? '0 : bit_cnt + CNT_W'(1);
    end

    // Decide the next direction and burst counts at each word end.
    always_comb begin
        phase_n   = phase;
        wr_left_n = wr_left;
        rd_left_n = rd_left;
        if (wdone) begin
            if (phase == PH_WR) begin
                if (!is_cmd) begin
                    wr_left_n = wr_left - LEN_W'(1);
                    if (wr_left == LEN_W'(1)) begin
                        phase_n   = PH_RD;
                        rd_left_n = LEN_W'(1);
                    end
                end else if (mode_ok && burst == BR_CAL_WR && len_nz) begin
                    wr_left_n = cal_len;
                end else begin
                    phase_n   = PH_RD;
                    rd_left_n = (mode_ok && burst == BR_CAL_RD && len_nz)
                                ? cal_len : LEN_W'(1);
                end
            end else begin
                rd_left_n = rd_left - LEN_W'(1);
                if (rd_left <= LEN_W'(1)) phase_n = PH_WR;
            end
        end
    end

    // Hold the phase and burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_WR;
            wr_left <= '0;
            rd_left <= '0;
        end else begin
            phase   <= phase_n;
            wr_left <= wr_left_n;
            rd_left <= rd_left_n;
        end
    end

    // Issue the one-cycle strobes for a completed write word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid   <= 1'b0;
            wr_err     <= 1'b0;
            conv_start <= 1'b0;
            wr_word    <= '0;
        end else begin
            wr_valid   <= wdone && phase == PH_WR &&  mode_ok;
            wr_err     <= wdone && phase == PH_WR && !mode_ok;
            conv_start <= wdone && phase == PH_WR && mode_ok && is_cmd
                          && word_in[CONV_POS];
            if (wdone && phase == PH_WR && mode_ok) wr_word <= word_in;
        end
    end
endmodule

// File: rtl/hdx_serial_port.sv
// Device-side half-duplex serial port on one shared data pin.
// Assumes clk runs at least 4x the serial clock; all serial inputs are
// asynchronous and synchronized here. Pin delays are whole clk cycles.
module hdx_serial_port
    import hdx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int LEN_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sel_n_in,
    input  logic              sdi_in,
    input  logic [LEN_W-1:0]  cal_len,
    input  logic [WORD_W-1:0] rd_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] wr_word,
    output logic              wr_valid,
    output logic              wr_err,
    output logic              conv_start
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [2:0]       sync_q;
    logic             sclk_s, sel_low, sdi_s;
    logic             rise_ev, fall_ev;
    hdx_phase_e       phase;
    logic [CNT_W-1:0] bit_cnt;
    logic [WORD_W-1:0] word_full;

    hdx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sdi_in, sel_n_in, sclk_in}), .q(sync_q)
    );

    assign sclk_s  =  sync_q[0];
    assign sel_low = ~sync_q[1];
    assign sdi_s   =  sync_q[2];

    hdx_edge i_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .en(sel_low),
        .rise(rise_ev), .fall(fall_ev)
    );

    hdx_phase_ctl #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_ctl (
        .clk(clk), .rst_n(rst_n), .rise(rise_ev), .word_in(word_full),
        .cal_len(cal_len), .phase(phase), .bit_cnt(bit_cnt),
        .wr_word(wr_word), .wr_valid(wr_valid), .wr_err(wr_err),
        .conv_start(conv_start)
    );

    hdx_shift #(.WORD_W(WORD_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .rise(rise_ev), .fall(fall_ev),
        .sdi(sdi_s), .phase_rd(phase == PH_RD), .bit_zero(bit_cnt == '0),
        .rd_word(rd_word), .word_full(word_full), .sdo(sdo)
    );

    // Drive the pin only in the read phase while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) sdo_oe <= 1'b0;
        else        sdo_oe <= (phase == PH_RD) && sel_low;
    end
endmodule

// File: rtl/hdx_serial_port_chk.sv
// Property checker for the serial port, attached with bind.
module hdx_serial_port_chk
    import hdx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             wr_valid,
    input logic             wr_err,
    input logic             conv_start,
    input logic             sel_low,
    input logic             fall_ev,
    input logic [CNT_W-1:0] bit_cnt,
    input hdx_phase_e       phase
);
    a_r4_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_low |=> !sdo_oe);

    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    a_r2_err_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> !wr_valid);

    a_r9_conv_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> wr_valid);

    a_r3_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(sdo));

    a_r5_turn_on_word_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase) |-> (bit_cnt == '0));
endmodule

bind hdx_serial_port hdx_serial_port_chk #(.CNT_W($clog2(WORD_W))) i_chk (
    .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe),
    .wr_valid(wr_valid), .wr_err(wr_err), .conv_start(conv_start),
    .sel_low(sel_low), .fall_ev(fall_ev), .bit_cnt(bit_cnt), .phase(phase)
);

// File: tb/test_hdx_serial_port.sv
module test_hdx_serial_port;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0, sel_n_in = 1'b1, sdi_in = 1'b0;
    logic [2:0]  cal_len = '0;
    logic [15:0] rd_word = '0;
    logic        sdo, sdo_oe, wr_valid, wr_err, conv_start;
    logic [15:0] wr_word;

    int checks = 0, fails = 0;
    int vcnt = 0, ecnt = 0, ccnt = 0;
    logic [15:0] last_word = '0;

    always #2 clk = ~clk;

    hdx_serial_port i_hdx_serial_port (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sel_n_in(sel_n_in),
        .sdi_in(sdi_in), .cal_len(cal_len), .rd_word(rd_word), .sdo(sdo),
        .sdo_oe(sdo_oe), .wr_word(wr_word), .wr_valid(wr_valid),
        .wr_err(wr_err), .conv_start(conv_start)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin vcnt++; last_word = wr_word; end
            if (wr_err) ecnt++;
            if (conv_start) ccnt++;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] wpat(int i);
        return ((16'(i) * 16'h9E37 + 16'h1234) & 16'hFFF0)
               | (16'(i & 1) << 3) | 16'h0001;
    endfunction

    function automatic logic [15:0] rpat(int i);
        return (16'(i) * 16'h3B1D) ^ 16'hA5C3;
    endfunction

    task automatic pulse(input logic d, output logic so, output logic oe);
        sdi_in = d;
        repeat (H) @(negedge clk);
        so = sdo; oe = sdo_oe;
        sclk_in = 1'b1;
        repeat (H) @(negedge clk);
        sclk_in = 1'b0;
    endtask

    // One 16-pulse word; checks pin direction and, for reads, the data.
    task automatic xfer(input logic [15:0] wv, input logic exp_oe,
                        input logic [15:0] exp_rd, input logic [15:0] nxt,
                        input bit pulsed, input string req);
        logic [15:0] got;
        logic so, oe;
        int oebad;
        got = '0; oebad = 0;
        if (pulsed) sel_n_in = 1'b0;
        for (int k = 0; k < 16; k++) begin
            if (k == 15) rd_word = nxt;
            pulse(wv[15-k], so, oe);
            got[15-k] = so;
            if (oe !== exp_oe) oebad++;
        end
        if (exp_oe) check(got === exp_rd, {req, " read data"}, got, exp_rd);
        check(oebad == 0, {req, " pin direction"}, oebad, 0);
        if (pulsed) begin
            repeat (H) @(negedge clk);
            sel_n_in = 1'b1;
            repeat (6) @(negedge clk);
            check(sdo_oe == 1'b0, "R4 deselected pin off", sdo_oe, 0);
            repeat (4) @(negedge clk);
        end
    endtask

    // A plain write followed by its read, with forwarding checked.
    task automatic pair(input logic [15:0] wv, input logic [15:0] rv,
                        input bit pulsed, input string req);
        int v0;
        v0 = vcnt;
        xfer(wv, 1'b0, 16'h0, rv, pulsed, req);
        check(vcnt == v0 + 1 && last_word == wv, {"R1 forward ", req}, last_word, wv);
        xfer(16'h0, 1'b1, rv, 16'h0, pulsed, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int nconv;
        int v0, e0, c0;
        logic so, oe;
        nconv = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(sdo_oe == 0 && sdo == 0, "R10 pin after reset", {sdo_oe, sdo}, 0);
        check(wr_valid == 0 && wr_err == 0 && conv_start == 0 && vcnt == 0,
              "R10 strobes after reset", vcnt, 0);

        // R1 R3 R4 sweep with pulsed select
        for (int i = 0; i < 24; i++) begin
            pair(wpat(i), rpat(i), 1'b1, "R3 pulsed");
            nconv += i & 1;
        end

        // R5 sweep with select held low
        sel_n_in = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 24; i < 48; i++) begin
            pair(wpat(i), rpat(i), 1'b0, "R5 held-low");
            nconv += i & 1;
        end
        for (int j = 4; j < 16; j++) pair((16'h1 << j) | 16'h1, ~(16'h1 << j), 1'b0, "R1 walking");
        check(ccnt == nconv, "R9 conversion count", ccnt, nconv);

        // R6 suspend mid-word with junk clocks while deselected
        sel_n_in = 1'b1;
        repeat (8) @(negedge clk);
        v0 = vcnt;
        sel_n_in = 1'b0;
        for (int k = 0; k < 8; k++) pulse(16'hC3A5 >> (15-k), so, oe);
        repeat (H) @(negedge clk);
        sel_n_in = 1'b1;
        repeat (H) @(negedge clk);
        for (int k = 0; k < 5; k++) pulse(k[0], so, oe);
        check(vcnt == v0 && sdo_oe == 0, "R6 ignored while deselected", vcnt, v0);
        sel_n_in = 1'b0;
        for (int k = 8; k < 16; k++) begin
            if (k == 15) rd_word = 16'h5A3C;
            pulse(16'hC3A5 >> (15-k), so, oe);
        end
        repeat (H) @(negedge clk);
        check(vcnt == v0 + 1 && last_word == 16'hC3A5, "R6 word resumed", last_word, 16'hC3A5);
        xfer(16'h0, 1'b1, 16'h5A3C, 16'h0, 1'b0, "R6 read after resume");

        // R2 rejected command carrying a read burst request
        cal_len = 3'd3;
        v0 = vcnt; e0 = ecnt;
        xfer(16'hF00C, 1'b0, 16'h0, 16'h1111, 1'b0, "R2 bad word");
        check(ecnt == e0 + 1 && vcnt == v0, "R2 error strobe", ecnt, e0 + 1);
        xfer(16'h0, 1'b1, 16'h1111, 16'h0, 1'b0, "R2 single read");
        xfer(16'h0021, 1'b0, 16'h0, 16'h2222, 1'b0, "R2 back to write");
        xfer(16'h0, 1'b1, 16'h2222, 16'h0, 1'b0, "R2 read");

        // R7 calibration read burst of 3
        c0 = ccnt;
        xfer(16'h8005, 1'b0, 16'h0, 16'hA001, 1'b0, "R7 command");
        xfer(16'h0, 1'b1, 16'hA001, 16'hB002, 1'b0, "R7 word 1");
        xfer(16'h0, 1'b1, 16'hB002, 16'hC003, 1'b0, "R7 word 2");
        xfer(16'h0, 1'b1, 16'hC003, 16'h0, 1'b0, "R7 word 3");
        xfer(16'h7001, 1'b0, 16'h0, 16'h4444, 1'b0, "R7 write after burst");
        check(last_word == 16'h7001, "R7 write after burst forwarded", last_word, 16'h7001);
        xfer(16'h0, 1'b1, 16'h4444, 16'h0, 1'b0, "R7 read");

        // R8 calibration write burst of 2; data words carry bit 3
        cal_len = 3'd2;
        v0 = vcnt; c0 = ccnt;
        xfer(16'h9003, 1'b0, 16'h0, 16'h0, 1'b0, "R8 command");
        xfer(16'h123F, 1'b0, 16'h0, 16'h0, 1'b0, "R8 data 1");
        check(last_word == 16'h123F, "R8 data 1 forwarded", last_word, 16'h123F);
        xfer(16'hABC9, 1'b0, 16'h0, 16'h7777, 1'b0, "R8 data 2");
        check(vcnt == v0 + 3 && last_word == 16'hABC9, "R8 burst count", vcnt, v0 + 3);
        check(ccnt == c0, "R9 no start from burst data", ccnt, c0);
        xfer(16'h0, 1'b1, 16'h7777, 16'h0, 1'b0, "R8 single read");

        // R11 zero-length burst requests
        cal_len = 3'd0;
        xfer(16'h0005, 1'b0, 16'h0, 16'h6666, 1'b0, "R11 read req len 0");
        xfer(16'h0, 1'b1, 16'h6666, 16'h0, 1'b0, "R11 single read");
        xfer(16'h0003, 1'b0, 16'h0, 16'h3333, 1'b0, "R11 write req len 0");
        xfer(16'h0, 1'b1, 16'h3333, 16'h0, 1'b0, "R11 turned around");
        xfer(16'h00F1, 1'b0, 16'h0, 16'h0, 1'b0, "R11 write phase again");

        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule